// File: doc/BRIEF.md
# Virtual Function Capability Register Controller

This block holds the settings one physical function uses to create virtual functions. System software reaches it through a configuration read/write port that takes a dword index, byte enables and write data. The block stores a requested virtual-function count, a control word and a system page size. It checks the requested count against a limit that depends on the migration setting. It then drives a live enable, an active-function count and an effective memory-space enable to the rest of the function.

Software first sets the requested count and then sets the enable bit. The limit is checked only at that moment. If the count is illegal, the functions stay off and a sticky error flag appears in the status half of the control word. A conventional reset uses the asynchronous reset pin. A reset aimed at the physical function is a synchronous pulse, and both return every settable field to its default. A reset aimed at one virtual function changes no register. It only produces a one-cycle strobe toward that function's resources.

Top module: `vfcap_regs`

## Requirements
- R1: After the asynchronous reset, the control word reads 0, the requested count reads 0, the system page size reads 1 (bit 0), and `vf_enabled`, `active_vfs`, `vf_mem_en` and `vf_flr_strobe` are 0.
- R2: Index 0 reads 32'h0001_0010. Index 1 bit 0 reads the migration-capable parameter. Index 3 reads {TOTAL_VFS[15:0], INITIAL_VFS[15:0]}. Index 5 reads {STRIDE[15:0], FIRST_OFFSET[15:0]}. Index 6 reads SUPPORTED_PAGES. Writes to these indices change nothing.
- R3: A write to index 2 that sets bit 0 (enable) while the functions are off, with a legal requested count, raises `vf_enabled` one cycle later and sets `active_vfs` to the count.
- R4: Legal means 1 ≤ count ≤ TOTAL_VFS when migration is capable and index 2 bit 1 is written as 1 in that same write. Otherwise legal means 1 ≤ count ≤ INITIAL_VFS.
- R5: An illegal count at enable time keeps `vf_enabled` at 0 and sets index 2 bit 16. Writing 1 to bit 16 with byte enable 2 clears that bit.
- R6: The requested count (index 4, bits 15:0) ignores writes while the stored enable bit is 1. Writing 0 to bit 0 of index 2 drops `vf_enabled` to 0 and `active_vfs` to 0.
- R7: A write changes only the byte lanes whose byte enable is set.
- R8: A system page size write (index 7) is kept only when the merged value has exactly one bit set and that bit is in SUPPORTED_PAGES. Otherwise the old value stays.
- R9: A `flr_pf` pulse returns every settable field to its reset value on the next cycle. It also turns the functions off. It takes priority over a write in the same cycle.
- R10: A `flr_vf` pulse naming index n (0-based) produces `vf_flr_strobe` with only bit n set for one cycle, one cycle later, when n < `active_vfs`. Otherwise the strobe stays 0. It changes no register or output count.
- R11: `vf_mem_en` equals `vf_enabled` ANDed with index 2 bit 3 (memory enable).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Conventional reset, asynchronous, active low |
| cfg_wr | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 3 | Dword index of the capability register |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| flr_pf | input | 1 | Function-level reset pulse aimed at the physical function |
| flr_vf | input | 1 | Function-level reset pulse aimed at one virtual function |
| flr_vf_num | input | VF_IDX_W | Index of the targeted virtual function |
| vf_enabled | output | 1 | Virtual functions are live |
| active_vfs | output | 16 | Number of live virtual functions |
| vf_mem_en | output | 1 | Effective memory-space enable for the virtual functions |
| vf_flr_strobe | output | TOTAL_VFS | One-hot reset strobe toward a single virtual function |

## Verification
Some properties are checked every cycle:
- `active_vfs` stays between 1 and the total while enabled, and is 0 otherwise.
- The system page size is always one supported bit.
- The per-function reset strobe is at most one-hot.
- A physical-function reset always turns the functions off.
- A virtual-function reset never moves the live count.

Other behaviour only the bench's scenarios can show:
- The limit that depends on migration, at both of its edges.
- The sticky error flag and how it is cleared.
- Merging by byte lane.
- That writes to the read-only words are ignored.
- That the count is locked while enabled.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;
  typedef enum logic [2:0] {
    A_HDR    = 3'd0,
    A_CAPS   = 3'd1,
    A_CTRL   = 3'd2,
    A_COUNTS = 3'd3,
    A_NUM    = 3'd4,
    A_RID    = 3'd5,
    A_SUPP   = 3'd6,
    A_SYSPG  = 3'd7
  } vfcap_addr_e;

  localparam int CTL_EN  = 0;
  localparam int CTL_MIG = 1;
  localparam int CTL_MSE = 3;
  localparam int STS_ERR = 16;
  localparam logic [31:0] HDR_WORD = 32'h0001_0010;
  localparam logic [31:0] PAGE_DEFAULT = 32'h0000_0001;

  function automatic logic [31:0] merge_be(input logic [31:0] old_w,
                                           input logic [31:0] new_w,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++)
      r[i*8 +: 8] = be[i] ? new_w[i*8 +: 8] : old_w[i*8 +: 8];
    return r;
  endfunction
endpackage

// File: rtl/vfcap_range_chk.sv
module vfcap_range_chk #(
  parameter int TOTAL_VFS   = 16,
  parameter int INITIAL_VFS = 8
) (
  input  logic [15:0] num,
  input  logic        mig,
  output logic        legal
);
  localparam logic [15:0] TOT16 = 16'(TOTAL_VFS);
  localparam logic [15:0] INI16 = 16'(INITIAL_VFS);

  logic [15:0] upper;

  always_comb begin
    upper = mig ? TOT16 : INI16;
    legal = (num != 16'd0) && (num <= upper);
  end
endmodule

// File: rtl/vfcap_page_sel.sv
module vfcap_page_sel #(
  parameter logic [31:0] SUPPORTED_PAGES = 32'h0000_0013
) (
  input  logic [31:0] cand,
  output logic        accept
);
  always_comb begin
    accept = $onehot(cand) && ((cand & ~SUPPORTED_PAGES) == 32'd0);
  end
endmodule

// File: rtl/vfcap_vf_flr.sv
module vfcap_vf_flr #(
  parameter int TOTAL_VFS = 16,
  localparam int IDX_W = (TOTAL_VFS > 1) ? $clog2(TOTAL_VFS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flr_pf,
  input  logic                 flr_vf,
  input  logic [IDX_W-1:0]     flr_vf_num,
  input  logic                 vf_en,
  input  logic [15:0]          active,
  output logic [TOTAL_VFS-1:0] strobe
);
  logic                 hit;
  logic [TOTAL_VFS-1:0] strobe_d;

  always_comb begin
    hit = flr_vf && vf_en && !flr_pf && (16'(flr_vf_num) < active);
  end

  for (genvar g = 0; g < TOTAL_VFS; g++) begin : g_bit
    always_comb strobe_d[g] = hit && (32'(flr_vf_num) == g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe <= '0;
    else        strobe <= strobe_d;
  end

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
endmodule

// File: rtl/vfcap_regs.sv
module vfcap_regs
  import vfcap_pkg::*;
#(
  parameter int          TOTAL_VFS       = 16,
  parameter int          INITIAL_VFS     = 8,
  parameter int          FIRST_OFFSET    = 2,
  parameter int          STRIDE          = 4,
  parameter logic [31:0] SUPPORTED_PAGES = 32'h0000_0013,
  parameter bit          MIGR_CAP        = 1'b1,
  localparam int VF_IDX_W = (TOTAL_VFS > 1) ? $clog2(TOTAL_VFS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [2:0]           cfg_addr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 flr_pf,
  input  logic                 flr_vf,
  input  logic [VF_IDX_W-1:0]  flr_vf_num,
  output logic                 vf_enabled,
  output logic [15:0]          active_vfs,
  output logic                 vf_mem_en,
  output logic [TOTAL_VFS-1:0] vf_flr_strobe
);
  localparam logic [15:0] TOT16 = 16'(TOTAL_VFS);

  logic        en_bit_q, en_bit_d;
  logic        mig_q, mig_d;
  logic        mse_q, mse_d;
  logic        err_q, err_d;
  logic [15:0] numvfs_q, numvfs_d;
  logic [31:0] syspg_q, syspg_d;
  logic        vf_en_q, vf_en_d;
  logic [15:0] active_q, active_d;

  logic        wr_ctrl_lo, wr_ctrl_hi, wr_num, wr_pg;
  logic        mig_new, num_legal, pg_ok;
  logic [31:0] num_merged, pg_merged;

  always_comb begin
    wr_ctrl_lo = cfg_wr && (cfg_addr == A_CTRL) && cfg_be[0];
    wr_ctrl_hi = cfg_wr && (cfg_addr == A_CTRL) && cfg_be[2];
    wr_num     = cfg_wr && (cfg_addr == A_NUM) && (|cfg_be[1:0]) && !en_bit_q;
    wr_pg      = cfg_wr && (cfg_addr == A_SYSPG);
    mig_new    = MIGR_CAP && cfg_wdata[CTL_MIG];
    num_merged = merge_be({16'h0, numvfs_q}, cfg_wdata, cfg_be);
    pg_merged  = merge_be(syspg_q, cfg_wdata, cfg_be);
  end

  vfcap_range_chk #(.TOTAL_VFS(TOTAL_VFS), .INITIAL_VFS(INITIAL_VFS)) i_range (
    .num(numvfs_q), .mig(mig_new), .legal(num_legal));

  vfcap_page_sel #(.SUPPORTED_PAGES(SUPPORTED_PAGES)) i_page (
    .cand(pg_merged), .accept(pg_ok));

  // next state
  always_comb begin
    en_bit_d = en_bit_q;
    mig_d    = mig_q;
    mse_d    = mse_q;
    err_d    = err_q;
    numvfs_d = numvfs_q;
    syspg_d  = syspg_q;
    vf_en_d  = vf_en_q;
    active_d = active_q;
    if (wr_ctrl_hi && cfg_wdata[STS_ERR]) err_d = 1'b0;
    if (wr_ctrl_lo) begin
      en_bit_d = cfg_wdata[CTL_EN];
      mig_d    = mig_new;
      mse_d    = cfg_wdata[CTL_MSE];
      if (!cfg_wdata[CTL_EN]) begin
        vf_en_d  = 1'b0;
        active_d = 16'd0;
      end else if (!vf_en_q) begin
        if (num_legal) begin
          vf_en_d  = 1'b1;
          active_d = numvfs_q;
        end else begin
          err_d = 1'b1;
        end
      end
    end
    if (wr_num) numvfs_d = num_merged[15:0];
    if (wr_pg && pg_ok) syspg_d = pg_merged;
    if (flr_pf) begin
      en_bit_d = 1'b0;
      mig_d    = 1'b0;
      mse_d    = 1'b0;
      err_d    = 1'b0;
      numvfs_d = 16'd0;
      syspg_d  = PAGE_DEFAULT;
      vf_en_d  = 1'b0;
      active_d = 16'd0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_bit_q <= 1'b0;
      mig_q    <= 1'b0;
      mse_q    <= 1'b0;
      err_q    <= 1'b0;
      numvfs_q <= 16'd0;
      syspg_q  <= PAGE_DEFAULT;
      vf_en_q  <= 1'b0;
      active_q <= 16'd0;
    end else begin
      en_bit_q <= en_bit_d;
      mig_q    <= mig_d;
      mse_q    <= mse_d;
      err_q    <= err_d;
      numvfs_q <= numvfs_d;
      syspg_q  <= syspg_d;
      vf_en_q  <= vf_en_d;
      active_q <= active_d;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = 32'd0;
    unique case (cfg_addr)
      A_HDR:    cfg_rdata = HDR_WORD;
      A_CAPS:   cfg_rdata = {31'd0, MIGR_CAP};
      A_CTRL:   begin
        cfg_rdata[CTL_EN]  = en_bit_q;
        cfg_rdata[CTL_MIG] = mig_q;
        cfg_rdata[CTL_MSE] = mse_q;
        cfg_rdata[STS_ERR] = err_q;
      end
      A_COUNTS: cfg_rdata = {16'(TOTAL_VFS), 16'(INITIAL_VFS)};
      A_NUM:    cfg_rdata = {16'd0, numvfs_q};
      A_RID:    cfg_rdata = {16'(STRIDE), 16'(FIRST_OFFSET)};
      A_SUPP:   cfg_rdata = SUPPORTED_PAGES;
      A_SYSPG:  cfg_rdata = syspg_q;
      default:  cfg_rdata = 32'd0;
    endcase
  end

  vfcap_vf_flr #(.TOTAL_VFS(TOTAL_VFS)) i_vf_flr (
    .clk(clk), .rst_n(rst_n), .flr_pf(flr_pf), .flr_vf(flr_vf),
    .flr_vf_num(flr_vf_num), .vf_en(vf_en_q), .active(active_q),
    .strobe(vf_flr_strobe));

  always_comb begin
    vf_enabled = vf_en_q;
    active_vfs = active_q;
    vf_mem_en  = vf_en_q && mse_q;
  end

  // R3
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vf_en_q |-> (active_q != 16'd0) && (active_q <= TOT16));
  // R6
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vf_en_q |-> (active_q == 16'd0));
  // R8
  page_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(syspg_q) && ((syspg_q & ~SUPPORTED_PAGES) == 32'd0));
  // R9
  pf_flr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flr_pf |=> !vf_enabled && (numvfs_q == 16'd0) && !en_bit_q);
  // R10
  vf_flr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flr_vf && !flr_pf && !cfg_wr) |=> $stable(active_vfs) && $stable(vf_enabled));
endmodule

// File: tb/test_vfcap_regs.sv
`timescale 1ns/1ps
module test_vfcap_regs;
  localparam int TOTAL = 16;
  localparam int IDXW  = $clog2(TOTAL);

  typedef struct packed {
    logic [7:0]  req;
    logic [2:0]  addr;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic [31:0] rd;
    logic        en;
    logic [15:0] act;
    logic        mse;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{8'd6, 3'd4, 4'h3, 32'd5,          32'd5,          1'b0, 16'd0,  1'b0}, // R6 count while off
    '{8'd3, 3'd2, 4'h1, 32'd1,          32'd1,          1'b1, 16'd5,  1'b0}, // R3 legal enable
    '{8'd6, 3'd4, 4'h3, 32'd7,          32'd5,          1'b1, 16'd5,  1'b0}, // R6 locked
    '{8'd6, 3'd2, 4'h1, 32'd0,          32'd0,          1'b0, 16'd0,  1'b0}, // R6 disable
    '{8'd4, 3'd4, 4'h3, 32'd12,         32'd12,         1'b0, 16'd0,  1'b0},
    '{8'd4, 3'd2, 4'h1, 32'd1,          32'h0001_0001,  1'b0, 16'd0,  1'b0}, // R4 12 > initial
    '{8'd5, 3'd2, 4'h4, 32'h0001_0000,  32'h0000_0001,  1'b0, 16'd0,  1'b0}, // R5 clear
    '{8'd4, 3'd2, 4'h1, 32'd3,          32'd3,          1'b1, 16'd12, 1'b0}, // R4 migration widens
    '{8'd6, 3'd2, 4'h1, 32'd0,          32'd0,          1'b0, 16'd0,  1'b0},
    '{8'd4, 3'd4, 4'h3, 32'd16,         32'd16,         1'b0, 16'd0,  1'b0},
    '{8'd4, 3'd2, 4'h1, 32'd3,          32'd3,          1'b1, 16'd16, 1'b0}, // R4 upper edge
    '{8'd6, 3'd2, 4'h1, 32'd0,          32'd0,          1'b0, 16'd0,  1'b0},
    '{8'd4, 3'd4, 4'h3, 32'd17,         32'd17,         1'b0, 16'd0,  1'b0},
    '{8'd4, 3'd2, 4'h1, 32'd3,          32'h0001_0003,  1'b0, 16'd0,  1'b0}, // R4 over total
    '{8'd5, 3'd2, 4'h4, 32'h0001_0000,  32'd3,          1'b0, 16'd0,  1'b0},
    '{8'd6, 3'd2, 4'h1, 32'd0,          32'd0,          1'b0, 16'd0,  1'b0},
    '{8'd4, 3'd4, 4'h3, 32'd0,          32'd0,          1'b0, 16'd0,  1'b0},
    '{8'd4, 3'd2, 4'h1, 32'd1,          32'h0001_0001,  1'b0, 16'd0,  1'b0}, // R4 zero count
    '{8'd5, 3'd2, 4'h5, 32'h0001_0000,  32'd0,          1'b0, 16'd0,  1'b0}, // R5
    '{8'd8, 3'd7, 4'hF, 32'd2,          32'd2,          1'b0, 16'd0,  1'b0}, // R8 accepted
    '{8'd8, 3'd7, 4'hF, 32'd6,          32'd2,          1'b0, 16'd0,  1'b0}, // R8 two bits
    '{8'd8, 3'd7, 4'hF, 32'd4,          32'd2,          1'b0, 16'd0,  1'b0}, // R8 unsupported
    '{8'd8, 3'd7, 4'hF, 32'h10,         32'h10,         1'b0, 16'd0,  1'b0},
    '{8'd8, 3'd7, 4'hF, 32'd0,          32'h10,         1'b0, 16'd0,  1'b0}, // R8 zero
    '{8'd2, 3'd3, 4'hF, 32'hFFFF_FFFF,  32'h0010_0008,  1'b0, 16'd0,  1'b0}, // R2
    '{8'd2, 3'd5, 4'hF, 32'hFFFF_FFFF,  32'h0004_0002,  1'b0, 16'd0,  1'b0},
    '{8'd2, 3'd6, 4'hF, 32'hFFFF_FFFF,  32'h0000_0013,  1'b0, 16'd0,  1'b0},
    '{8'd2, 3'd0, 4'hF, 32'hFFFF_FFFF,  32'h0001_0010,  1'b0, 16'd0,  1'b0},
    '{8'd2, 3'd1, 4'hF, 32'hFFFF_FFFF,  32'd1,          1'b0, 16'd0,  1'b0},
    '{8'd7, 3'd4, 4'h2, 32'h0000_0300,  32'h300,        1'b0, 16'd0,  1'b0}, // R7 upper lane
    '{8'd7, 3'd4, 4'h1, 32'h0000_FF06,  32'h306,        1'b0, 16'd0,  1'b0}, // R7 lower lane
    '{8'd7, 3'd4, 4'h3, 32'd3,          32'd3,          1'b0, 16'd0,  1'b0},
    '{8'd11,3'd2, 4'h1, 32'd9,          32'd9,          1'b1, 16'd3,  1'b1}  // R11 memory enable
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cfg_wr;
  logic [2:0]       cfg_addr;
  logic [3:0]       cfg_be;
  logic [31:0]      cfg_wdata;
  logic [31:0]      cfg_rdata;
  logic             flr_pf, flr_vf;
  logic [IDXW-1:0]  flr_vf_num;
  logic             vf_enabled, vf_mem_en;
  logic [15:0]      active_vfs;
  logic [TOTAL-1:0] vf_flr_strobe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vfcap_regs i_vfcap_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .flr_pf(flr_pf), .flr_vf(flr_vf), .flr_vf_num(flr_vf_num),
    .vf_enabled(vf_enabled), .active_vfs(active_vfs), .vf_mem_en(vf_mem_en),
    .vf_flr_strobe(vf_flr_strobe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = 3'd0; cfg_be = 4'h0; cfg_wdata = 32'd0;
    flr_pf = 1'b0; flr_vf = 1'b0; flr_vf_num = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 ctrl", 3'd2, 32'd0);
    rd_chk("R1 count", 3'd4, 32'd0);
    rd_chk("R1 page", 3'd7, 32'd1);
    chk("R1 outputs", {14'd0, vf_enabled, vf_mem_en, active_vfs}, 32'd0);
    chk("R1 strobe", 32'(vf_flr_strobe), 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].addr, VECS[i].be, VECS[i].wdata);
      chk($sformatf("R%0d vec%0d rd", VECS[i].req, i), cfg_rdata, VECS[i].rd);
      chk($sformatf("R%0d vec%0d out", VECS[i].req, i),
          {14'd0, vf_enabled, vf_mem_en, active_vfs},
          {14'd0, VECS[i].en, VECS[i].mse, VECS[i].act});
    end

    // R10 targeted strobe, count untouched
    @(negedge clk); flr_vf = 1'b1; flr_vf_num = IDXW'(2);
    @(negedge clk); flr_vf = 1'b0;
    chk("R10 strobe", 32'(vf_flr_strobe), 32'd4);
    chk("R10 count kept", 32'(active_vfs), 32'd3);
    @(negedge clk);
    chk("R10 strobe one cycle", 32'(vf_flr_strobe), 32'd0);
    rd_chk("R10 ctrl kept", 3'd2, 32'd9);
    @(negedge clk); flr_vf = 1'b1; flr_vf_num = IDXW'(5);
    @(negedge clk); flr_vf = 1'b0;
    chk("R10 out of range", 32'(vf_flr_strobe), 32'd0);
    chk("R10 enable kept", 32'(vf_enabled), 32'd1);

    // R9 PF reset beats a same-cycle page write
    @(negedge clk);
    flr_pf = 1'b1; cfg_wr = 1'b1; cfg_addr = 3'd7; cfg_be = 4'hF; cfg_wdata = 32'd2;
    @(negedge clk);
    flr_pf = 1'b0; cfg_wr = 1'b0;
    chk("R9 outputs", {14'd0, vf_enabled, vf_mem_en, active_vfs}, 32'd0);
    rd_chk("R9 page", 3'd7, 32'd1);
    rd_chk("R9 ctrl", 3'd2, 32'd0);
    rd_chk("R9 count", 3'd4, 32'd0);

    // R1 conventional reset mid-run
    wr(3'd4, 4'h3, 32'd4);
    wr(3'd7, 4'hF, 32'h10);
    wr(3'd2, 4'h1, 32'd1);
    chk("R3 enable again", 32'(active_vfs), 32'd4);
    #2 rst_n = 1'b0;
    #1 chk("R1 async clear", 32'(vf_enabled), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    rd_chk("R1 page after reset", 3'd7, 32'd1);
    rd_chk("R1 count after reset", 3'd4, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule